// File: doc/BRIEF.md
# Tag-Wakeup Issue Queue

This block holds decoded operations that wait for their source operands. Each operation arrives with up to two source tags and a ready flag per tag. It sits in one of a fixed number of slots until every source is ready, then goes to a single functional unit. The slots never shift, so an operation can leave from any slot. This means a younger operation whose operands are ready can go ahead of an older one that is still waiting.

Producers of results broadcast their destination tag on a wake port. The block compares that tag with every stored source that is still waiting, and each match marks that operand ready. When several entries can issue, the entry that entered first wins. This keeps an old operation from being passed over indefinitely by newer ones. A flush input clears the whole queue in one cycle.

Entry and exit both use valid/ready handshakes.
- Entry side: `alloc_ready` is low exactly while every slot is occupied. An offer made then is not taken and must be held or repeated.
- Exit side: the block shows its choice on `issue_*` with `issue_valid`. The consumer may hold `issue_ready` low for any number of cycles. While it does, the entry stays in the queue.

Top module: `issue_queue_tagwake`

## Requirements
- R1: After reset, the queue is empty: `issue_valid` is 0, `full` is 0 and `alloc_ready` is 1.
- R2: An entry is taken on a clock edge where `alloc_valid` and `alloc_ready` are both 1, and it is visible from the next cycle. When all DEPTH slots are occupied, `full` is 1 and `alloc_ready` is 0. An offer made while full leaves the queue contents unchanged.
- R3: A cycle with `wake_valid` = 1 marks ready every stored waiting source whose tag equals `wake_tag`. The effect is visible at the issue port from the next cycle. A non-matching tag wakes nothing, and a ready source stays ready.
- R4: `issue_valid` is 1 only when some stored entry has both sources ready. An entry with a waiting source is never presented.
- R5: Among ready entries, the one allocated earliest is presented, whatever slot it occupies.
- R6: Removal is out of order. A ready younger entry issues while an older entry is still waiting.
- R7: While `issue_valid` is 1 and `issue_ready` is 0, the entry is held and `issue_valid` stays 1 in the next cycle (barring flush).
- R8: When `wake_valid` is 1 and `wake_tag` equals a source tag of the entry being allocated in the same cycle, that source is stored as ready.
- R9: `flush` = 1 empties every slot at the next edge. An allocation offered in the same cycle is dropped, and `issue_valid` is 0 during the flush cycle.
- R10: An entry leaves on the edge where `issue_valid` and `issue_ready` are both 1, and its slot is free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clear all entries |
| alloc_valid | input | 1 | New entry offered |
| alloc_ready | output | 1 | Queue can accept an entry |
| alloc_op | input | OP_W | Operation code of the new entry |
| alloc_tag_a | input | TAG_W | First source tag |
| alloc_rdy_a | input | 1 | First source already available |
| alloc_tag_b | input | TAG_W | Second source tag |
| alloc_rdy_b | input | 1 | Second source already available |
| wake_valid | input | 1 | Result tag broadcast present |
| wake_tag | input | TAG_W | Broadcast result tag |
| issue_valid | output | 1 | An entry is presented for issue |
| issue_ready | input | 1 | Functional unit accepts the entry |
| issue_op | output | OP_W | Operation code of the presented entry |
| issue_tag_a | output | TAG_W | First source tag of the presented entry |
| issue_tag_b | output | TAG_W | Second source tag of the presented entry |
| full | output | 1 | All slots occupied |

## Verification
All state changes land one clock edge after their cause:
- an allocation, a wake broadcast or a flush shows up at the issue port in the cycle after the edge that took it;
- the issue port itself is combinational on the stored state, so the next choice appears in the cycle after an accepted issue.

The bench drives inputs just after a rising edge and reads outputs shortly after that. Each result is therefore checked in the cycle it is due. Checks that need a one-cycle gap, such as a wake with a non-matching tag or an offer while full, look at the port right after that single edge and before any other stimulus.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEPTH_DEF = 8;
  localparam int unsigned IQ_TAG_W_DEF = 6;
  localparam int unsigned IQ_OP_W_DEF  = 8;
endpackage

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
  parameter int unsigned DEPTH = iq_pkg::IQ_DEPTH_DEF
) (
  input  logic [DEPTH-1:0] busy,
  output logic [DEPTH-1:0] pick_oh,
  output logic             any_free
);
  // lowest-index empty slot receives the next entry
  always_comb begin
    pick_oh  = '0;
    any_free = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (!busy[i] && !any_free) begin
        pick_oh[i] = 1'b1;
        any_free   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_tag_cam.sv
module iq_tag_cam #(
  parameter int unsigned DEPTH = iq_pkg::IQ_DEPTH_DEF,
  parameter int unsigned TAG_W = iq_pkg::IQ_TAG_W_DEF
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            pending,
  input  logic                        wake_valid,
  input  logic [TAG_W-1:0]            wake_tag,
  output logic [DEPTH-1:0]            hit
);
  // one comparator per slot, only waiting sources can match
  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
    assign hit[g] = wake_valid & pending[g] & (tags[g] == wake_tag);
  end
endmodule

// File: rtl/iq_age_select.sv
module iq_age_select #(
  parameter int unsigned DEPTH = iq_pkg::IQ_DEPTH_DEF,
  localparam int unsigned AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            req,
  input  logic [DEPTH-1:0][AGE_W-1:0] age,
  output logic [DEPTH-1:0]            grant,
  output logic [AGE_W-1:0]            idx,
  output logic                        any
);
  logic [AGE_W-1:0] best;
  logic [DEPTH-1:0] older_req;

  // smallest age wins; strict compare keeps the lowest index on a tie
  always_comb begin
    any  = 1'b0;
    best = '0;
    idx  = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (req[i] && (!any || age[i] < best)) begin
        any  = 1'b1;
        best = age[i];
        idx  = AGE_W'(i);
      end
    end
    grant = '0;
    if (any) grant[idx] = 1'b1;
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_older
    assign older_req[g] = req[g] && (age[g] < age[idx]);
  end

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_is_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  assert_oldest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (older_req == '0));
endmodule

// File: rtl/issue_queue_tagwake.sv
module issue_queue_tagwake #(
  parameter int unsigned DEPTH = iq_pkg::IQ_DEPTH_DEF,
  parameter int unsigned TAG_W = iq_pkg::IQ_TAG_W_DEF,
  parameter int unsigned OP_W  = iq_pkg::IQ_OP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [OP_W-1:0]  alloc_op,
  input  logic [TAG_W-1:0] alloc_tag_a,
  input  logic             alloc_rdy_a,
  input  logic [TAG_W-1:0] alloc_tag_b,
  input  logic             alloc_rdy_b,
  input  logic             wake_valid,
  input  logic [TAG_W-1:0] wake_tag,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [OP_W-1:0]  issue_op,
  output logic [TAG_W-1:0] issue_tag_a,
  output logic [TAG_W-1:0] issue_tag_b,
  output logic             full
);
  localparam int unsigned AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]            vld, rdy_a, rdy_b;
  logic [DEPTH-1:0][AGE_W-1:0] age;
  logic [DEPTH-1:0][OP_W-1:0]  op_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_a_q, tag_b_q;

  logic [DEPTH-1:0] hit_a, hit_b, req, grant, alloc_oh;
  logic [AGE_W-1:0] sel_idx, new_age;
  logic             sel_any, any_free, alloc_fire, issue_fire;
  logic             in_rdy_a, in_rdy_b;
  logic [CNT_W-1:0] count;

  iq_free_pick #(.DEPTH(DEPTH)) u_free (
    .busy(vld), .pick_oh(alloc_oh), .any_free(any_free));

  iq_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cam_a (
    .tags(tag_a_q), .pending(vld & ~rdy_a), .wake_valid(wake_valid),
    .wake_tag(wake_tag), .hit(hit_a));

  iq_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cam_b (
    .tags(tag_b_q), .pending(vld & ~rdy_b), .wake_valid(wake_valid),
    .wake_tag(wake_tag), .hit(hit_b));

  assign req = vld & rdy_a & rdy_b;

  iq_age_select #(.DEPTH(DEPTH)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(req), .age(age),
    .grant(grant), .idx(sel_idx), .any(sel_any));

  always_comb begin
    count = '0;
    for (int i = 0; i < int'(DEPTH); i++) count = count + CNT_W'(vld[i]);
  end

  assign full        = ~any_free;
  assign alloc_ready = any_free;
  assign alloc_fire  = alloc_valid & any_free & ~flush;
  assign issue_valid = sel_any & ~flush;
  assign issue_fire  = issue_valid & issue_ready;
  assign issue_op    = op_q[sel_idx];
  assign issue_tag_a = tag_a_q[sel_idx];
  assign issue_tag_b = tag_b_q[sel_idx];

  // incoming sources also see this cycle's broadcast
  assign in_rdy_a = alloc_rdy_a | (wake_valid & (alloc_tag_a == wake_tag));
  assign in_rdy_b = alloc_rdy_b | (wake_valid & (alloc_tag_b == wake_tag));
  // new entry is youngest among those that remain after this edge
  assign new_age  = AGE_W'(count - CNT_W'(issue_fire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= '0;
      rdy_a   <= '0;
      rdy_b   <= '0;
      age     <= '0;
      op_q    <= '0;
      tag_a_q <= '0;
      tag_b_q <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (issue_fire && grant[i]) begin
          vld[i] <= 1'b0;
        end else if (vld[i]) begin
          if (hit_a[i]) rdy_a[i] <= 1'b1;
          if (hit_b[i]) rdy_b[i] <= 1'b1;
          if (issue_fire && (age[i] > age[sel_idx])) age[i] <= age[i] - 1'b1;
        end else if (alloc_fire && alloc_oh[i]) begin
          vld[i]     <= 1'b1;
          op_q[i]    <= alloc_op;
          tag_a_q[i] <= alloc_tag_a;
          tag_b_q[i] <= alloc_tag_b;
          rdy_a[i]   <= in_rdy_a;
          rdy_b[i]   <= in_rdy_b;
          age[i]     <= new_age;
        end
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !issue_fire) |=> (count == $past(count) + CNT_W'(1)));
  assert_issue_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> (issue_valid || flush));
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  assert_issue_drains_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !alloc_fire && !flush) |=> (count == $past(count) - CNT_W'(1)));

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_chk
    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[g] && rdy_a[g] && rdy_b[g] && !flush && !(issue_fire && grant[g]))
        |=> (vld[g] && rdy_a[g] && rdy_b[g]));
  end
endmodule

// File: tb/issue_queue_tagwake_tb.sv
module issue_queue_tagwake_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       alloc_valid = 1'b0;
  logic       alloc_ready;
  logic [7:0] alloc_op = '0;
  logic [5:0] alloc_tag_a = '0, alloc_tag_b = '0;
  logic       alloc_rdy_a = 1'b0, alloc_rdy_b = 1'b0;
  logic       wake_valid = 1'b0;
  logic [5:0] wake_tag = '0;
  logic       issue_valid;
  logic       issue_ready = 1'b0;
  logic [7:0] issue_op;
  logic [5:0] issue_tag_a, issue_tag_b;
  logic       full;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  issue_queue_tagwake u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_op(alloc_op),
    .alloc_tag_a(alloc_tag_a), .alloc_rdy_a(alloc_rdy_a),
    .alloc_tag_b(alloc_tag_b), .alloc_rdy_b(alloc_rdy_b),
    .wake_valid(wake_valid), .wake_tag(wake_tag),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
    .issue_tag_a(issue_tag_a), .issue_tag_b(issue_tag_b), .full(full));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input logic [7:0] op, input logic [5:0] ta, input logic ra,
                       input logic [5:0] tb, input logic rb);
    alloc_op = op; alloc_tag_a = ta; alloc_rdy_a = ra;
    alloc_tag_b = tb; alloc_rdy_b = rb; alloc_valid = 1'b1;
    tick();
    alloc_valid = 1'b0;
    #1;
  endtask

  task automatic wake(input logic [5:0] t);
    wake_valid = 1'b1; wake_tag = t;
    tick();
    wake_valid = 1'b0;
    #1;
  endtask

  task automatic take();
    issue_ready = 1'b1;
    tick();
    issue_ready = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 issue_valid", int'(issue_valid), 0);
    check("R1 full", int'(full), 0);
    check("R1 alloc_ready", int'(alloc_ready), 1);
  endtask

  task automatic t_basic();
    alloc(8'h11, 6'd1, 1'b1, 6'd2, 1'b1);
    check("R2 R4 entry visible", int'(issue_valid), 1);
    check("R2 op", int'(issue_op), 'h11);
    check("R2 tag_b", int'(issue_tag_b), 2);
    take();
    check("R10 removed after issue", int'(issue_valid), 0);
  endtask

  task automatic t_wake();
    alloc(8'h22, 6'd5, 1'b0, 6'd3, 1'b1);
    check("R4 waiting not presented", int'(issue_valid), 0);
    wake(6'd7);
    check("R3 non-matching tag ignored", int'(issue_valid), 0);
    wake(6'd5);
    check("R3 matching tag wakes", int'(issue_valid), 1);
    check("R3 woken op", int'(issue_op), 'h22);
    take();
  endtask

  task automatic t_out_of_order();
    alloc(8'h31, 6'd4, 1'b1, 6'd9, 1'b0);
    alloc(8'h32, 6'd1, 1'b1, 6'd1, 1'b1);
    check("R6 younger ready issues first", int'(issue_op), 'h32);
    tick();
    check("R7 held under back-pressure valid", int'(issue_valid), 1);
    check("R7 held op", int'(issue_op), 'h32);
    take();
    check("R6 older still waiting", int'(issue_valid), 0);
    wake(6'd9);
    check("R3 second-source wake", int'(issue_op), 'h31);
    take();
  endtask

  task automatic t_age_order();
    alloc(8'h61, 6'd1, 1'b1, 6'd1, 1'b1);
    alloc(8'h62, 6'd12, 1'b0, 6'd1, 1'b1);
    take();
    alloc(8'h63, 6'd12, 1'b0, 6'd1, 1'b1);
    wake(6'd12);
    check("R5 older entry in higher slot first", int'(issue_op), 'h62);
    take();
    check("R5 then younger", int'(issue_op), 'h63);
    take();
    check("R10 drained", int'(issue_valid), 0);
  endtask

  task automatic t_same_cycle();
    wake_valid = 1'b1; wake_tag = 6'd20;
    alloc(8'h71, 6'd20, 1'b0, 6'd20, 1'b0);
    wake_valid = 1'b0;
    check("R8 same-cycle wake of incoming", int'(issue_valid), 1);
    check("R8 op", int'(issue_op), 'h71);
    take();
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) alloc(8'(8'h50 + k), 6'd30, 1'b0, 6'd1, 1'b1);
    check("R2 full when all slots used", int'(full), 1);
    check("R2 alloc_ready low when full", int'(alloc_ready), 0);
    alloc(8'h99, 6'd1, 1'b1, 6'd1, 1'b1);
    check("R2 offer while full ignored", int'(issue_valid), 0);
    wake(6'd30);
    for (int k = 0; k < 8; k++) begin
      check("R5 program order drain", int'(issue_op), 'h50 + k);
      take();
      if (k == 0) check("R10 slot freed", int'(full), 0);
    end
    check("R2 full offer never stored", int'(issue_valid), 0);
  endtask

  task automatic t_flush();
    alloc(8'h81, 6'd1, 1'b1, 6'd1, 1'b1);
    alloc(8'h82, 6'd1, 1'b1, 6'd1, 1'b1);
    alloc(8'h83, 6'd9, 1'b0, 6'd1, 1'b1);
    flush = 1'b1;
    alloc_op = 8'h84; alloc_rdy_a = 1'b1; alloc_rdy_b = 1'b1; alloc_valid = 1'b1;
    #1;
    check("R9 no issue during flush", int'(issue_valid), 0);
    tick();
    flush = 1'b0; alloc_valid = 1'b0;
    #1;
    check("R9 empty after flush", int'(issue_valid), 0);
    check("R9 not full", int'(full), 0);
    wake(6'd9);
    check("R9 flushed waiter gone", int'(issue_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_wake();
    t_out_of_order();
    t_age_order();
    t_same_cycle();
    t_full();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule